// File: doc/BRIEF.md
# Move-Programmed Exposed-Datapath Core

This block is a small processor core whose instructions contain no operations, only data transports. Each instruction word has one move slot per transport bus. A move copies a value from a source to a destination. The source can be a general register, a function-unit result port or an immediate constant. The destination can be a general register, an operand port or a trigger port. A write to a trigger port starts that unit's operation. The trigger address that is written picks the opcode.

The core has eight general registers, a single-cycle ALU, a load-store unit with its own data memory, and four boolean predicate registers that can guard individual moves. Software can feed a result port straight into another unit's port, so temporaries never occupy a general register. The program also carries the burden of port discipline: when two moves collide on one destination port, the core raises an error flag and resolves the collision by bus priority.

A host fills the instruction array through a write port, holds the core in reset, then raises `run`. While `run` is high, the core executes one instruction word per clock from address zero upward. Register, predicate and memory contents can be observed through read-only peek ports.

Top module: `tta_core`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter, all general registers, all predicate bits, both ALU registers, the LSU result and the LSU operand are cleared to zero at that edge.
- R2: A move slot is 21 bits. From the most significant bit down it holds: guard enable (1), guard invert (1), guard index (2), source code (4), immediate (8), destination code (5). Bus 0 occupies the least significant slot of the 63-bit word. Source codes 0..7 read registers r0..r7. Code 8 yields the immediate sign-extended to 16 bits, code 9 the ALU result and code 10 the LSU result. Destination codes 24..31 write registers r0..r7.
- R3: The ALU trigger aliases are destination codes 3 ADD, 4 SUB, 5 AND, 6 OR and 7 XOR. Each computes operand OP trigger value, with SUB computing operand minus trigger and all results taken modulo 2^16. The result can be read by the next instruction and keeps its value until the ALU is triggered again.
- R4: Destination 1 is the ALU operand register. An operand moved in the same instruction as an ALU trigger is the one that trigger uses. The operand is kept for all later triggers until it is overwritten.
- R5: Destination codes 8+k (equal) and 12+k (signed less-than, operand < trigger) write their outcome to predicate register k (k = 0..3). They also load the ALU result with 1 or 0.
- R6: A result port used as the source of a move into a trigger port delivers the value it held at the start of that instruction, with no register involved.
- R7: Destination 2 is the store-data operand. Destination 16 triggers a load and destination 17 triggers a store, each using the moved value's low 4 bits as the word address. A store writes the store-data operand, including one moved in the same instruction. Load data reaches the LSU result two instructions after the trigger, is not visible one instruction after it, and holds until the next load completes.
- R8: A slot with guard enable set takes effect only when predicate[guard index] XOR guard invert is 1. Otherwise that move has no effect.
- R9: Destination code 0 is an idle slot with no effect. While `run` is low, no move takes effect and the program counter holds. While `run` is high, the program counter advances by one each clock, modulo 32.
- R10: If two active moves in one instruction target the same port, `move_err` is high in that instruction's cycle and the lowest-numbered bus wins. Every ALU trigger code counts as one port, both LSU trigger codes count as one port, and each register counts as its own port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Instruction array write enable |
| prog_addr | input | 5 | Instruction array write address |
| prog_word | input | 63 | Instruction word to store |
| run | input | 1 | Execute one instruction per clock when high |
| peek_reg_idx | input | 3 | General register selected for observation |
| peek_reg_val | output | 16 | Contents of the selected register |
| peek_mem_addr | input | 4 | Data memory word selected for observation |
| peek_mem_val | output | 16 | Contents of the selected memory word |
| bool_state | output | 4 | Predicate register contents |
| pc_out | output | 5 | Current program counter |
| move_err | output | 1 | Destination conflict in the current instruction |

## Verification
A wrong internal state mostly stays hidden until a later move copies it somewhere visible. A corrupted ALU or LSU result register shows only once the program moves that result port into a register, which happens one instruction later for the ALU and two instructions later for loads. A stale operand register shows at the next trigger that relies on it. A wrong predicate shows as a guarded move that lands or vanishes against expectation. The programs are therefore laid out so that every internal value is funnelled into a register or memory word within at most three instructions, and then read through the peek ports.

// File: rtl/tta_pkg.sv
`timescale 1ns/1ps
package tta_pkg;
    localparam int DW         = 16;
    localparam int NBUS       = 3;
    localparam int NREG       = 8;
    localparam int NBOOL      = 4;
    localparam int IMW        = 8;
    localparam int IMEM_DEPTH = 32;
    localparam int DMEM_DEPTH = 16;
    localparam int SRCW       = 4;
    localparam int DSTW       = 5;

    localparam int RAW   = $clog2(NREG);
    localparam int BAW   = $clog2(NBOOL);
    localparam int IAW   = $clog2(IMEM_DEPTH);
    localparam int DAW   = $clog2(DMEM_DEPTH);
    localparam int SLOTW = 2 + BAW + SRCW + IMW + DSTW;
    localparam int IW    = NBUS * SLOTW;

    localparam logic [SRCW-1:0] SRC_IMM = 4'd8;
    localparam logic [SRCW-1:0] SRC_ALU = 4'd9;
    localparam logic [SRCW-1:0] SRC_LSU = 4'd10;

    localparam logic [DSTW-1:0] D_NONE  = 5'd0;
    localparam logic [DSTW-1:0] D_ALU_A = 5'd1;
    localparam logic [DSTW-1:0] D_LSU_D = 5'd2;
    localparam logic [DSTW-1:0] D_ADD   = 5'd3;
    localparam logic [DSTW-1:0] D_EQ    = 5'd8;
    localparam logic [DSTW-1:0] D_LT    = 5'd12;
    localparam logic [DSTW-1:0] D_LD    = 5'd16;
    localparam logic [DSTW-1:0] D_ST    = 5'd17;
    localparam logic [DSTW-1:0] D_REG   = 5'd24;

    typedef struct packed {
        logic            gen;
        logic            ginv;
        logic [BAW-1:0]  gidx;
        logic [SRCW-1:0] src;
        logic [IMW-1:0]  imm;
        logic [DSTW-1:0] dst;
    } slot_t;

    typedef enum logic [2:0] {
        P_NONE, P_ALU_A, P_ALU_T, P_LSU_D, P_LSU_T, P_REG
    } port_e;

    typedef enum logic [2:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_EQ, OP_LT
    } alu_op_e;

    function automatic port_e dst_port(input logic [DSTW-1:0] d);
        if (d == D_ALU_A)                       return P_ALU_A;
        if (d == D_LSU_D)                       return P_LSU_D;
        if (d >= D_ADD && d < D_LD)             return P_ALU_T;
        if (d == D_LD || d == D_ST)             return P_LSU_T;
        if (d >= D_REG && 32'(d) < 32'(D_REG) + NREG) return P_REG;
        return P_NONE;
    endfunction

    function automatic alu_op_e alu_op_of(input logic [DSTW-1:0] d);
        if (d >= D_LT) return OP_LT;
        if (d >= D_EQ) return OP_EQ;
        case (d - D_ADD)
            5'd0:    return OP_ADD;
            5'd1:    return OP_SUB;
            5'd2:    return OP_AND;
            5'd3:    return OP_OR;
            default: return OP_XOR;
        endcase
    endfunction

    function automatic logic [DW-1:0] sext_imm(input logic [IMW-1:0] v);
        return {{(DW-IMW){v[IMW-1]}}, v};
    endfunction
endpackage

// File: rtl/tta_slot.sv
`timescale 1ns/1ps
module tta_slot
    import tta_pkg::*;
(
    input  slot_t                    slot,
    input  logic                     en,
    input  logic [NBOOL-1:0]         bools,
    input  logic [NREG-1:0][DW-1:0]  rf,
    input  logic [DW-1:0]            alu_res,
    input  logic [DW-1:0]            lsu_res,
    output logic                     act,
    output port_e                    port,
    output logic [DW-1:0]            val
);
    logic guard_ok;

    always_comb begin
        guard_ok = !slot.gen || (bools[slot.gidx] ^ slot.ginv);
        port     = dst_port(slot.dst);
        act      = en && guard_ok && (port != P_NONE);
        if (32'(slot.src) < NREG)     val = rf[slot.src[RAW-1:0]];
        else if (slot.src == SRC_IMM) val = sext_imm(slot.imm);
        else if (slot.src == SRC_ALU) val = alu_res;
        else if (slot.src == SRC_LSU) val = lsu_res;
        else                          val = '0;
    end
endmodule

// File: rtl/tta_alu.sv
`timescale 1ns/1ps
module tta_alu
    import tta_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          a_we,
    input  logic [DW-1:0] a_in,
    input  logic          trig,
    input  alu_op_e       op,
    input  logic [DW-1:0] t_in,
    output logic [DW-1:0] res,
    output logic          flag
);
    logic [DW-1:0] a_q, a_eff, nxt;

    always_comb begin
        a_eff = a_we ? a_in : a_q;
        flag  = 1'b0;
        case (op)
            OP_ADD: nxt = a_eff + t_in;
            OP_SUB: nxt = a_eff - t_in;
            OP_AND: nxt = a_eff & t_in;
            OP_OR:  nxt = a_eff | t_in;
            OP_XOR: nxt = a_eff ^ t_in;
            OP_EQ: begin
                flag = (a_eff == t_in);
                nxt  = {{(DW-1){1'b0}}, flag};
            end
            default: begin
                flag = ($signed(a_eff) < $signed(t_in));
                nxt  = {{(DW-1){1'b0}}, flag};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            res <= '0;
        end else begin
            if (a_we) a_q <= a_in;
            if (trig) res <= nxt;
        end
    end
endmodule

// File: rtl/tta_lsu.sv
`timescale 1ns/1ps
module tta_lsu
    import tta_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           d_we,
    input  logic [DW-1:0]  d_in,
    input  logic           trig,
    input  logic           store,
    input  logic [DW-1:0]  addr_in,
    input  logic [DAW-1:0] peek_addr,
    output logic [DW-1:0]  res,
    output logic           ld_pend,
    output logic [DW-1:0]  peek_data
);
    logic [DW-1:0]  mem [DMEM_DEPTH];
    logic [DW-1:0]  d_q, d_eff;
    logic [DAW-1:0] addr_q, addr_now;

    assign d_eff     = d_we ? d_in : d_q;
    assign addr_now  = addr_in[DAW-1:0];
    assign peek_data = mem[peek_addr];

    always_ff @(posedge clk) begin
        if (trig && store) mem[addr_now] <= d_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q     <= '0;
            addr_q  <= '0;
            ld_pend <= 1'b0;
            res     <= '0;
        end else begin
            if (d_we) d_q <= d_in;
            ld_pend <= trig && !store;
            if (trig && !store) addr_q <= addr_now;
            if (ld_pend) res <= mem[addr_q];
        end
    end
endmodule

// File: rtl/tta_core.sv
`timescale 1ns/1ps
module tta_core
    import tta_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           prog_we,
    input  logic [IAW-1:0] prog_addr,
    input  logic [IW-1:0]  prog_word,
    input  logic           run,
    input  logic [RAW-1:0] peek_reg_idx,
    output logic [DW-1:0]  peek_reg_val,
    input  logic [DAW-1:0] peek_mem_addr,
    output logic [DW-1:0]  peek_mem_val,
    output logic [NBOOL-1:0] bool_state,
    output logic [IAW-1:0] pc_out,
    output logic           move_err
);
    logic [IW-1:0]           imem [IMEM_DEPTH];
    logic [IW-1:0]           word;
    logic [IAW-1:0]          pc_q;
    logic [NREG-1:0][DW-1:0] rf_q;
    logic [NBOOL-1:0]        bool_q;

    logic [NBUS-1:0] act_b;
    port_e           port_b [NBUS];
    logic [DW-1:0]   val_b  [NBUS];
    logic [DSTW-1:0] dst_b  [NBUS];

    logic [DW-1:0] alu_res, lsu_res;
    logic          alu_flag, ld_pend;

    logic                    a_we, alu_trig, d_we, lsu_trig, lsu_store;
    logic [DW-1:0]           a_val, t_val, d_val, lsu_addr;
    logic [DSTW-1:0]         t_dst;
    logic [NREG-1:0]         rf_we;
    logic [NREG-1:0][DW-1:0] rf_wd;

    assign word = imem[pc_q];

    always_ff @(posedge clk) begin
        if (prog_we) imem[prog_addr] <= prog_word;
    end

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        slot_t s;
        assign s        = slot_t'(word[b*SLOTW +: SLOTW]);
        assign dst_b[b] = s.dst;
        tta_slot u_slot (
            .slot(s), .en(run), .bools(bool_q), .rf(rf_q),
            .alu_res(alu_res), .lsu_res(lsu_res),
            .act(act_b[b]), .port(port_b[b]), .val(val_b[b])
        );
    end

    // Higher buses first so that bus 0 is written last and wins.
    always_comb begin
        a_we = 1'b0; alu_trig = 1'b0; d_we = 1'b0; lsu_trig = 1'b0; lsu_store = 1'b0;
        a_val = '0; t_val = '0; d_val = '0; lsu_addr = '0; t_dst = D_NONE;
        rf_we = '0; rf_wd = '0;
        for (int b = NBUS - 1; b >= 0; b--) begin
            if (act_b[b]) begin
                case (port_b[b])
                    P_ALU_A: begin a_we = 1'b1; a_val = val_b[b]; end
                    P_ALU_T: begin alu_trig = 1'b1; t_val = val_b[b]; t_dst = dst_b[b]; end
                    P_LSU_D: begin d_we = 1'b1; d_val = val_b[b]; end
                    P_LSU_T: begin
                        lsu_trig  = 1'b1;
                        lsu_addr  = val_b[b];
                        lsu_store = (dst_b[b] == D_ST);
                    end
                    P_REG: begin
                        rf_we[dst_b[b][RAW-1:0]] = 1'b1;
                        rf_wd[dst_b[b][RAW-1:0]] = val_b[b];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        move_err = 1'b0;
        for (int i = 0; i < NBUS; i++) begin
            for (int j = i + 1; j < NBUS; j++) begin
                if (act_b[i] && act_b[j] && port_b[i] == port_b[j] &&
                    (port_b[i] != P_REG || dst_b[i] == dst_b[j]))
                    move_err = 1'b1;
            end
        end
    end

    tta_alu u_alu (
        .clk(clk), .rst(rst), .a_we(a_we), .a_in(a_val), .trig(alu_trig),
        .op(alu_op_of(t_dst)), .t_in(t_val), .res(alu_res), .flag(alu_flag)
    );

    tta_lsu u_lsu (
        .clk(clk), .rst(rst), .d_we(d_we), .d_in(d_val), .trig(lsu_trig),
        .store(lsu_store), .addr_in(lsu_addr), .peek_addr(peek_mem_addr),
        .res(lsu_res), .ld_pend(ld_pend), .peek_data(peek_mem_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            rf_q   <= '0;
            bool_q <= '0;
        end else begin
            if (run) pc_q <= pc_q + 1'b1;
            for (int r = 0; r < NREG; r++) begin
                if (rf_we[r]) rf_q[r] <= rf_wd[r];
            end
            if (alu_trig && t_dst >= D_EQ)
                bool_q[t_dst[BAW-1:0]] <= alu_flag;
        end
    end

    assign peek_reg_val = rf_q[peek_reg_idx];
    assign bool_state   = bool_q;
    assign pc_out       = pc_q;
endmodule

// File: rtl/tta_core_chk.sv
`timescale 1ns/1ps
module tta_core_chk
    import tta_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           run,
    input logic [IAW-1:0] pc,
    input logic           move_err,
    input logic           alu_trig,
    input logic [DW-1:0]  alu_res,
    input logic           ld_pend,
    input logic [DW-1:0]  lsu_res
);
    p_pc_clear_r1: assert property (@(posedge clk) rst |=> pc == '0);

    p_pc_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> pc == $past(pc));

    p_pc_step_r9: assert property (@(posedge clk) disable iff (rst)
        run |=> pc == IAW'($past(pc) + 1'b1));

    p_no_err_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !run |-> !move_err);

    p_alu_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !alu_trig |=> alu_res == $past(alu_res));

    p_lsu_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !ld_pend |=> lsu_res == $past(lsu_res));
endmodule

bind tta_core tta_core_chk u_chk (
    .clk(clk), .rst(rst), .run(run), .pc(pc_q), .move_err(move_err),
    .alu_trig(alu_trig), .alu_res(alu_res), .ld_pend(ld_pend), .lsu_res(lsu_res)
);

// File: tb/tta_core_test.sv
`timescale 1ns/1ps
module tta_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        prog_we = 1'b0;
    logic [4:0]  prog_addr = '0;
    logic [62:0] prog_word = '0;
    logic        run = 1'b0;
    logic [2:0]  peek_reg_idx = '0;
    logic [15:0] peek_reg_val;
    logic [3:0]  peek_mem_addr = '0;
    logic [15:0] peek_mem_val;
    logic [3:0]  bool_state;
    logic [4:0]  pc_out;
    logic        move_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tta_core uut (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_word(prog_word), .run(run), .peek_reg_idx(peek_reg_idx),
        .peek_reg_val(peek_reg_val), .peek_mem_addr(peek_mem_addr),
        .peek_mem_val(peek_mem_val), .bool_state(bool_state),
        .pc_out(pc_out), .move_err(move_err)
    );

    // Encodings taken from the requirements.
    localparam logic [3:0] S_IMM = 4'd8, S_ALU = 4'd9, S_LSU = 4'd10;
    localparam logic [4:0] T_A = 5'd1, T_SD = 5'd2, T_ADD = 5'd3, T_SUB = 5'd4,
                           T_XOR = 5'd7, T_EQ = 5'd8, T_LD = 5'd16, T_ST = 5'd17;

    function automatic logic [4:0] rd(input int r);
        return 5'(24 + r);
    endfunction

    function automatic logic [20:0] mv(input logic [3:0] src, input logic [7:0] imm,
                                       input logic [4:0] dst);
        return {1'b0, 1'b0, 2'd0, src, imm, dst};
    endfunction

    function automatic logic [20:0] gmv(input logic inv, input logic [1:0] gi,
                                        input logic [3:0] src, input logic [7:0] imm,
                                        input logic [4:0] dst);
        return {1'b1, inv, gi, src, imm, dst};
    endfunction

    function automatic logic [62:0] ins(input logic [20:0] s0, s1, s2);
        return {s2, s1, s0};
    endfunction

    function automatic logic [15:0] ref_alu(input logic [4:0] d, input logic [7:0] a8, b8);
        logic signed [15:0] a, b;
        a = 16'(signed'(a8));
        b = 16'(signed'(b8));
        if (d == 5'd3) return a + b;
        if (d == 5'd4) return a - b;
        if (d == 5'd5) return a & b;
        if (d == 5'd6) return a | b;
        if (d == 5'd7) return a ^ b;
        if (d < 5'd12) return {15'd0, a == b};
        return {15'd0, a < b};
    endfunction

    localparam int NV = 9;
    localparam logic [20:0] VEC [NV] = '{
        {5'd3,  8'd5,   8'd7},
        {5'd3,  8'h7F,  8'h01},
        {5'd4,  8'd3,   8'd5},
        {5'd5,  8'hF0,  8'h3C},
        {5'd6,  8'h81,  8'h02},
        {5'd7,  8'hFF,  8'h0F},
        {5'd9,  8'd4,   8'd4},
        {5'd14, 8'hFE,  8'h01},
        {5'd12, 8'd3,   8'h80}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input int r, input logic [15:0] exp);
        @(negedge clk);
        peek_reg_idx = 3'(r);
        #0.1;
        chk(tag, 32'(peek_reg_val), 32'(exp));
    endtask

    task automatic put(input int a, input logic [62:0] w);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = 5'(a); prog_word = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic clear_prog();
        for (int a = 0; a < 32; a++) put(a, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        run = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic exec(input int n);
        @(negedge clk);
        run = 1'b1;
        repeat (n) @(negedge clk);
        run = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        clear_prog();
        do_reset();
        #0.1;
        chk("R1 pc", 32'(pc_out), 0);
        chk("R1 bools", 32'(bool_state), 0);
        chk("R1 err", 32'(move_err), 0);
        chk_reg("R1 r0", 0, 16'h0);
        chk_reg("R1 r7", 7, 16'h0);

        // R3 R5: ALU vector table, operand then trigger, result into r3
        for (int k = 0; k < NV; k++) begin
            logic [4:0]  d;
            logic [7:0]  a, b;
            logic [15:0] e;
            {d, a, b} = VEC[k];
            e = ref_alu(d, a, b);
            put(0, ins(mv(S_IMM, a, T_A), mv(S_IMM, b, d), '0));
            put(1, ins(mv(S_ALU, 0, rd(3)), '0, '0));
            do_reset();
            exec(2);
            chk_reg($sformatf("R3 vec%0d", k), 3, e);
            if (d >= 5'd8)
                chk($sformatf("R5 bool vec%0d", k), 32'(bool_state[d[1:0]]), 32'(e[0]));
        end

        // R2: sign-extended immediates into registers
        clear_prog();
        put(0, ins(mv(S_IMM, 8'h85, rd(1)), mv(S_IMM, 8'h12, rd(2)), '0));
        do_reset();
        exec(1);
        chk_reg("R2 neg imm", 1, 16'hFF85);
        chk_reg("R2 pos imm", 2, 16'h0012);

        // R4 R3: operand persistence and result hold
        clear_prog();
        put(0, ins(mv(S_IMM, 8'd10, T_A), mv(S_IMM, 8'd3, T_ADD), '0));
        put(1, ins(mv(S_IMM, 8'd4, T_ADD), mv(S_ALU, 0, rd(1)), '0));
        put(2, ins(mv(S_ALU, 0, rd(2)), '0, '0));
        put(3, ins(mv(S_IMM, 8'd9, rd(5)), '0, '0));
        put(4, ins(mv(S_ALU, 0, rd(3)), '0, '0));
        do_reset();
        exec(5);
        chk_reg("R4 first", 1, 16'd13);
        chk_reg("R4 kept operand", 2, 16'd14);
        chk_reg("R3 result hold", 3, 16'd14);

        // R6: result port bypass into trigger
        clear_prog();
        put(0, ins(mv(S_IMM, 8'd6, T_A), mv(S_IMM, 8'd2, T_SUB), '0));
        put(1, ins(mv(S_ALU, 0, T_ADD), mv(S_ALU, 0, rd(1)), '0));
        put(2, ins(mv(S_ALU, 0, rd(2)), '0, '0));
        do_reset();
        exec(3);
        chk_reg("R6 old value", 1, 16'd4);
        chk_reg("R6 bypass sum", 2, 16'd10);

        // R7: store then load with two-instruction latency
        clear_prog();
        put(0, ins(mv(S_IMM, 8'h55, T_SD), mv(S_IMM, 8'd5, T_ST), '0));
        put(1, ins(mv(S_IMM, 8'd5, T_LD), '0, '0));
        put(2, ins(mv(S_LSU, 0, rd(1)), '0, '0));
        put(3, ins(mv(S_LSU, 0, rd(2)), '0, '0));
        put(4, ins('0, '0, '0));
        put(5, ins(mv(S_LSU, 0, rd(3)), '0, '0));
        do_reset();
        exec(6);
        chk_reg("R7 not yet", 1, 16'h0);
        chk_reg("R7 load", 2, 16'h0055);
        chk_reg("R7 hold", 3, 16'h0055);
        peek_mem_addr = 4'd5;
        #0.1;
        chk("R7 mem", 32'(peek_mem_val), 32'h55);

        // R8: guards
        clear_prog();
        put(0, ins(mv(S_IMM, 8'd1, T_A), mv(S_IMM, 8'd1, 5'd11), '0));
        put(1, ins(gmv(1'b0, 2'd3, S_IMM, 8'h11, rd(1)),
                   gmv(1'b1, 2'd3, S_IMM, 8'h22, rd(2)),
                   gmv(1'b0, 2'd0, S_IMM, 8'h33, rd(3))));
        do_reset();
        exec(2);
        chk("R5 eq sets b3", 32'(bool_state), 32'h8);
        chk_reg("R8 true guard", 1, 16'h0011);
        chk_reg("R8 inverted false", 2, 16'h0);
        chk_reg("R8 false guard", 3, 16'h0);

        // R10: destination conflicts, bus 0 wins
        clear_prog();
        put(0, ins(mv(S_IMM, 8'h0A, rd(1)), mv(S_IMM, 8'h0B, rd(1)), mv(S_IMM, 8'h0C, rd(2))));
        put(1, ins('0, mv(S_IMM, 8'd1, T_EQ), mv(S_IMM, 8'd5, T_XOR)));
        put(2, ins(mv(S_ALU, 0, rd(5)), '0, '0));
        do_reset();
        @(negedge clk);
        run = 1'b1;
        #0.1;
        chk("R10 err reg clash", 32'(move_err), 1);
        @(negedge clk);
        #0.1;
        chk("R10 err trigger clash", 32'(move_err), 1);
        @(negedge clk);
        #0.1;
        chk("R10 err clear", 32'(move_err), 0);
        @(negedge clk);
        run = 1'b0;
        chk_reg("R10 bus0 wins", 1, 16'h000A);
        chk_reg("R10 other bus", 2, 16'h000C);
        chk_reg("R10 lower trigger", 5, 16'h0);

        // R9: run low holds everything, idle slots do nothing
        clear_prog();
        put(0, ins('0, mv(S_IMM, 8'h44, rd(6)), '0));
        do_reset();
        repeat (3) @(negedge clk);
        #0.1;
        chk("R9 pc hold", 32'(pc_out), 0);
        chk_reg("R9 no move", 6, 16'h0);
        exec(1);
        #0.1;
        chk("R9 pc step", 32'(pc_out), 1);
        chk_reg("R9 move", 6, 16'h0044);
        chk_reg("R9 idle slot", 0, 16'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule